// File: doc/BRIEF.md
# Layer-Count Coincidence Trigger

This block watches the comparator hit flags of a six-layer detector, one set per bunch crossing. For every crossing it works out which layers saw at least one hit, counts those layers and compares the count against a programmable threshold. When the count reaches the threshold, the layer-trigger enable and the pretrigger enable are both set, and the threshold is not zero, it raises a trigger. The decision uses only the hits of that one crossing. It does not wait for hits to spread over time and it does not match hit patterns, so it answers faster than a pattern-based trigger path.

The per-crossing layer count and the trigger bit are registered together. Both appear one clock after the crossing they describe. A saturating counter totals the triggers issued, and a synchronous strobe clears it. A typical setting is a threshold of 2, which fires on any crossing where at least two layers are hit. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `layer_coinc_trig`

## Requirements
- R1: While reset is asserted, and after it is released with idle inputs, the layer count, the trigger and the trigger total all read 0.
- R2: Layer L owns bits [L*32 +: 32] of the hit bus. A layer counts as hit if any bit of its slice is 1. A single set bit at the lowest or the highest position of a slice is enough.
- R3: The layer count output equals the number of hit layers (0 to 6) of the crossing sampled at the previous rising clock edge.
- R4: The trigger output is 1 exactly one clock after a crossing whose layer count is greater than or equal to the threshold, provided both enables are 1 and the threshold is not 0. Otherwise it is 0.
- R5: With the layer-trigger enable at 0, no trigger is issued, whatever the hits are.
- R6: With the pretrigger enable at 0, no trigger is issued, whatever the hits are.
- R7: A threshold of 0 disables the trigger, even when layers are hit.
- R8: The trigger total increases by exactly 1 on the same edge that sets the trigger output, and it changes at no other time except a clear.
- R9: Once the trigger total reaches all ones it holds there while triggers keep coming.
- R10: When the clear strobe is sampled high, the trigger total becomes 0 on that edge, even if a trigger is issued on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hits_i | input | NLAYERS*STRIPS (192) | Comparator hit flags, 32 per layer, layer 0 in the lowest bits |
| trig_en_i | input | 1 | Layer-trigger enable |
| pretrig_en_i | input | 1 | Pretrigger enable |
| thresh_i | input | CNT_W (3) | Minimum number of hit layers; 0 disables |
| cnt_clr_i | input | 1 | Synchronous clear of the trigger total |
| layer_cnt_o | output | CNT_W (3) | Hit-layer count of the previous crossing |
| trig_o | output | 1 | Layer-count trigger |
| trig_total_o | output | TOT_W (32) | Saturating number of issued triggers |

## Verification
The count is tried on single-bit hits at the bottom and top edge of each layer's slice, which separates a correct per-layer OR from slices that are offset or cut short. It is also tried on dense hits across all six layers, and on random sparse and dense patterns that compare the count with an independent tally. The threshold is swept around the count, with counts of 5 versus 6 at a threshold of 6 and 1 versus 2 at a threshold of 2, to tell "greater or equal" apart from "greater". Each enable is dropped on its own and the threshold is set to 0 while hits are present, so that each gate is seen to block on its own. The total is driven into saturation on a narrowed counter and cleared on a cycle that also triggers, which shows that the clear wins over the count.

// File: rtl/ltrig_pkg.sv
package ltrig_pkg;

  typedef struct packed {
    logic layer_en;
    logic pretrig_en;
  } gate_t;

  function automatic logic gate_open(input gate_t g);
    return g.layer_en & g.pretrig_en;
  endfunction

endpackage

// File: rtl/ltrig_rst_sync.sv
module ltrig_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ltrig_layer_or.sv
module ltrig_layer_or #(
  parameter int NLAYERS = 6,
  parameter int STRIPS  = 32,
  localparam int BUS_W  = NLAYERS * STRIPS
) (
  input  logic [BUS_W-1:0]   hits_i,
  output logic [NLAYERS-1:0] layer_hit_o
);

  for (genvar l = 0; l < NLAYERS; l++) begin : g_layer
    assign layer_hit_o[l] = |hits_i[l*STRIPS +: STRIPS];
  end

endmodule

// File: rtl/ltrig_popcount.sv
module ltrig_popcount #(
  parameter int NLAYERS = 6,
  parameter int CNT_W   = $clog2(NLAYERS + 1)
) (
  input  logic [NLAYERS-1:0] layer_hit_i,
  output logic [CNT_W-1:0]   count_o
);

  always_comb begin
    count_o = '0;
    for (int l = 0; l < NLAYERS; l++) begin
      count_o = count_o + CNT_W'(layer_hit_i[l]);
    end
  end

endmodule

// File: rtl/ltrig_decide.sv
module ltrig_decide
  import ltrig_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  gate_t            gate_i,
  output logic             trig_next_o,
  output logic [CNT_W-1:0] count_o,
  output logic             trig_o
);

  logic [CNT_W-1:0] count_d;
  logic             trig_d;

  always_comb begin
    count_d = count_i;
    trig_d  = gate_open(gate_i) & (thresh_i != '0) & (count_i >= thresh_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      trig_o  <= 1'b0;
    end else begin
      count_o <= count_d;
      trig_o  <= trig_d;
    end
  end

  assign trig_next_o = trig_d;

endmodule

// File: rtl/ltrig_counter.sv
module ltrig_counter #(
  parameter int TOT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [TOT_W-1:0] total_o
);

  logic [TOT_W-1:0] total_d;
  logic             total_en;
  logic             at_max;

  always_comb begin
    at_max   = &total_o;
    total_en = clr_i | (inc_i & ~at_max);
    if (clr_i) total_d = '0;
    else       total_d = total_o + TOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        total_o <= '0;
    else if (total_en) total_o <= total_d;
  end

endmodule

// File: rtl/layer_coinc_trig.sv
module layer_coinc_trig
  import ltrig_pkg::*;
#(
  parameter int NLAYERS = 6,
  parameter int STRIPS  = 32,
  parameter int TOT_W   = 32,
  localparam int BUS_W  = NLAYERS * STRIPS,
  localparam int CNT_W  = $clog2(NLAYERS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] hits_i,
  input  logic             trig_en_i,
  input  logic             pretrig_en_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             cnt_clr_i,
  output logic [CNT_W-1:0] layer_cnt_o,
  output logic             trig_o,
  output logic [TOT_W-1:0] trig_total_o
);

  logic               rst_n_s;
  logic [NLAYERS-1:0] layer_hit;
  logic [CNT_W-1:0]   layer_sum;
  logic               trig_next;
  gate_t              gate;

  assign gate.layer_en   = trig_en_i;
  assign gate.pretrig_en = pretrig_en_i;

  ltrig_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  ltrig_layer_or #(.NLAYERS(NLAYERS), .STRIPS(STRIPS)) u_or (
    .hits_i      (hits_i),
    .layer_hit_o (layer_hit)
  );

  ltrig_popcount #(.NLAYERS(NLAYERS), .CNT_W(CNT_W)) u_pop (
    .layer_hit_i (layer_hit),
    .count_o     (layer_sum)
  );

  ltrig_decide #(.CNT_W(CNT_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .count_i     (layer_sum),
    .thresh_i    (thresh_i),
    .gate_i      (gate),
    .trig_next_o (trig_next),
    .count_o     (layer_cnt_o),
    .trig_o      (trig_o)
  );

  ltrig_counter #(.TOT_W(TOT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .inc_i   (trig_next),
    .clr_i   (cnt_clr_i),
    .total_o (trig_total_o)
  );

endmodule

// File: rtl/layer_coinc_trig_chk.sv
module layer_coinc_trig_chk #(
  parameter int NLAYERS = 6,
  parameter int TOT_W   = 32,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_en_i,
  input logic             pretrig_en_i,
  input logic [CNT_W-1:0] thresh_i,
  input logic             cnt_clr_i,
  input logic [CNT_W-1:0] layer_cnt_o,
  input logic             trig_o,
  input logic [TOT_W-1:0] trig_total_o
);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    layer_cnt_o <= CNT_W'(NLAYERS));

  // R4
  trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> ($past(trig_en_i) && $past(pretrig_en_i) && ($past(thresh_i) != '0)
                && (layer_cnt_o >= $past(thresh_i))));

  // R8
  total_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trig_total_o) |-> (trig_o || $past(cnt_clr_i)));

  // R9
  total_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&$past(trig_total_o)) && !$past(cnt_clr_i)) |-> (&trig_total_o));

  // R10
  total_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_clr_i) |-> (trig_total_o == '0));

endmodule

bind layer_coinc_trig layer_coinc_trig_chk #(
  .NLAYERS (NLAYERS),
  .TOT_W   (TOT_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_en_i    (trig_en_i),
  .pretrig_en_i (pretrig_en_i),
  .thresh_i     (thresh_i),
  .cnt_clr_i    (cnt_clr_i),
  .layer_cnt_o  (layer_cnt_o),
  .trig_o       (trig_o),
  .trig_total_o (trig_total_o)
);

// File: tb/layer_coinc_trig_bench.sv
`timescale 1ns/1ps
module layer_coinc_trig_bench;

  localparam int NL   = 6;
  localparam int SW   = 32;
  localparam int BW   = NL * SW;
  localparam int TW   = 4;

  logic          clk;
  logic          rst_n;
  logic [BW-1:0] hits;
  logic          ten, pten, clr;
  logic [2:0]    thr;
  logic [2:0]    cnt_o;
  logic          trig;
  logic [TW-1:0] total;

  int errors = 0;
  int checks = 0;
  int exp_cnt = 0;
  int exp_trig = 0;
  int exp_total = 0;
  bit done = 0;

  layer_coinc_trig #(.NLAYERS(NL), .STRIPS(SW), .TOT_W(TW)) u_layer_coinc_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .hits_i       (hits),
    .trig_en_i    (ten),
    .pretrig_en_i (pten),
    .thresh_i     (thr),
    .cnt_clr_i    (clr),
    .layer_cnt_o  (cnt_o),
    .trig_o       (trig),
    .trig_total_o (total)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int count_layers(input logic [BW-1:0] h);
    int n = 0;
    for (int l = 0; l < NL; l++) begin
      bit any = 0;
      for (int b = 0; b < SW; b++) if (h[l*SW + b]) any = 1;
      if (any) n++;
    end
    return n;
  endfunction

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic [BW-1:0] h, input logic te, input logic pe,
                      input int th, input logic cl, input string tag);
    int n;
    bit fire;
    hits = h; ten = te; pten = pe; thr = 3'(th); clr = cl;
    @(posedge clk);
    n = count_layers(h);
    fire = te && pe && (th != 0) && (n >= th);
    exp_cnt  = n;
    exp_trig = fire ? 1 : 0;
    if (cl) exp_total = 0;
    else if (fire && exp_total < (1 << TW) - 1) exp_total++;
    @(negedge clk);
    check({"R3 ", tag}, int'(cnt_o), exp_cnt);
    check({"R4 ", tag}, int'(trig), exp_trig);
    check({"R8 ", tag}, int'(total), exp_total);
  endtask

  function automatic logic [BW-1:0] one_bit(input int layer, input int bit_i);
    logic [BW-1:0] v = '0;
    v[layer*SW + bit_i] = 1'b1;
    return v;
  endfunction

  function automatic logic [BW-1:0] rand_hits(input int density);
    logic [BW-1:0] v = '0;
    for (int l = 0; l < NL; l++)
      if (($urandom % 100) < density) v[l*SW + ($urandom % SW)] = 1'b1;
    return v;
  endfunction

  initial begin
    #150000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] h;
    rst_n = 1'b0; hits = '0; ten = 0; pten = 0; thr = 0; clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check("R1 cnt", int'(cnt_o), 0);
    check("R1 trig", int'(trig), 0);
    check("R1 total", int'(total), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 cnt after release", int'(cnt_o), 0);
    check("R1 total after release", int'(total), 0);

    // R2: edge bits of every slice, threshold 1
    for (int l = 0; l < NL; l++) begin
      step(one_bit(l, 0), 1, 1, 1, 0, "R2 low bit");
      step(one_bit(l, SW-1), 1, 1, 1, 0, "R2 high bit");
    end
    step('1, 1, 1, 2, 0, "R3 all layers");
    step('0, 1, 1, 2, 0, "R3 no hits");

    // R4 threshold boundaries
    step(one_bit(0, 3), 1, 1, 2, 0, "R4 one of two");
    step(one_bit(0, 3) | one_bit(4, 9), 1, 1, 2, 0, "R4 two of two");
    h = '1; h[5*SW +: SW] = '0;
    step(h, 1, 1, 6, 0, "R4 five of six");
    step('1, 1, 1, 6, 0, "R4 six of six");

    // R5 R6 R7 gates
    step('1, 0, 1, 2, 0, "R5 layer enable off");
    step('1, 1, 0, 2, 0, "R6 pretrigger enable off");
    step('1, 1, 1, 0, 0, "R7 threshold zero");
    check("R7 no trigger", int'(trig), 0);

    // R10 clear with simultaneous trigger
    step('1, 1, 1, 1, 1, "R10 clear wins");
    check("R10 total zero", int'(total), 0);

    // R9 saturation on narrowed total
    for (int i = 0; i < 20; i++) step('1, 1, 1, 3, 0, "R9 saturate");
    check("R9 held at max", int'(total), (1 << TW) - 1);
    step('0, 1, 1, 3, 1, "R10 clear");

    // random patterns
    for (int i = 0; i < 300; i++)
      step(rand_hits((i % 3) * 40 + 10), ($urandom % 8) != 0, ($urandom % 8) != 0,
           $urandom % 7, ($urandom % 40) == 0, "R3 random");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule